// File: doc/BRIEF.md
# Byte-Wide Quadrature Counter Channel

This block is one 24-bit up/down counter channel that a host drives through an 8-bit port with two addresses. Writes to the control address are decoded into commands that clear or load the counter, snapshot it, set flags back to zero, and program three small configuration registers. These registers hold the count mode, the input and index options, and the index polarity and timing. The data address carries 24-bit values one byte at a time, least significant byte first, under an internal byte pointer. Data writes fill a preset register. Data reads return bytes of an output latch.

The counter cannot be written directly. The host places a value in the preset register and then issues a transfer command. To read the count, the host first copies it into the output latch and then reads that latch. A separate front end supplies count-enable and direction pulses, an index level and a noise indication. The block returns to that front end a filter-clock prescaler value and the quadrature resolution that was programmed. Four count modes control what happens at the ends of the range. Range-limit and modulo-N use the preset as their upper bound, and the lower bound is always zero.

Top module: `qcnt_channel`

## Requirements
- R1: After reset, a status read returns 0x00, the output latch reads as zero, psc_o and qmode_o are 0, and flag_o is low.
- R2: A control write selects its target with bits 7:5: 000 = reset/load command, 001 = counter mode (bits 4:3 quadrature resolution, bits 2:1 count mode), 010 = I/O control, 011 = index control; other target codes do nothing.
- R3: In a reset/load command, bit 0 returns the byte pointer to the low byte. Each data access uses the byte the pointer selects and then advances the pointer, wrapping to the low byte after the third access. Data writes fill the preset register and data reads return output-latch bytes.
- R4: Reset/load code 0x02 clears the counter, 0x08 copies the preset into the counter, and 0x10 copies the counter into the output latch. Any of these may be combined with bit 0 in a single write.
- R5: A count pulse changes the counter only while I/O control bit 0 is 1. Status bit 5 reads 1 when the last counted step was up and 0 when it was down.
- R6: Count mode 0 (wrap) goes from 2^24-1 up to 0 and sets the carry flag, and goes from 0 down to 2^24-1 and sets the borrow and sign flags. A carry clears the sign flag.
- R7: Count mode 1 (range limit) holds the counter at the preset when counting up and at 0 when counting down, and sets carry or borrow when a step is refused.
- R8: Count mode 2 (non-recycle) wraps once, sets carry or borrow, and then ignores count pulses until the next counter clear or load.
- R9: Count mode 3 (modulo-N) reloads 0 when counting up from the preset and reloads the preset when counting down from 0.
- R10: The status byte is {00, up/down, error, sign, compare, carry, borrow}, from bit 7 down to bit 0. Compare is set when a step lands on the preset value. A noise_i pulse sets the error flag. Code 0x04 clears borrow, carry, compare, sign and the index event, and code 0x06 clears the error flag.
- R11: When I/O control bit 1 is 0, an index edge loads the preset into the counter. Index control bit 1 selects the rising edge (1) or the falling edge (0). With index control bit 0 set, the load happens only on an edge that comes in the same cycle as a count pulse, and that pulse is then not counted.
- R12: Code 0x18 copies the low preset byte to psc_o. qmode_o shows counter-mode bits 4:3.
- R13: I/O control bits 4:3 select the source of flag_o: 0 = carry, 1 = compare, 2 = carry or borrow, 3 = index event.
- R14: A counter clear, load or index load in the same cycle as a count pulse takes priority, and the pulse is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe |
| addr_i | input | 1 | 0 = data address, 1 = control/status address |
| wdata_i | input | 8 | Host write byte |
| rdata_o | output | 8 | Host read byte (latch byte or status) |
| cnt_en_i | input | 1 | Count pulse from the front end |
| cnt_up_i | input | 1 | Direction of the count pulse, 1 = up |
| index_i | input | 1 | Index input level |
| noise_i | input | 1 | Noise detected by the front end |
| flag_o | output | 1 | Selected flag output |
| psc_o | output | 8 | Filter clock prescaler value |
| qmode_o | output | 2 | Programmed quadrature resolution |

## Verification
The bench pushes each mode to its ends. It steps past 2^24-1 and below 0 in wrap mode, against the preset in range-limit mode, through the one-shot wrap in non-recycle mode, and around the preset in modulo-N mode. A design with the bound comparison off by one would stop at or reload from the wrong value. A design whose non-recycle hold never releases would stay frozen after a new load. Byte-pointer wrap and the combined pointer-reset-plus-transfer command are both checked, since a design that does not wrap the pointer would return a stale byte on the fourth read. Index tests cover both polarities and synchronous qualification, and a last case issues a clear in the same cycle as a count pulse to show that commands win over counting.

// File: rtl/qcnt_pkg.sv
package qcnt_pkg;
  typedef enum logic [2:0] {
    TGT_RLD = 3'b000,
    TGT_CMR = 3'b001,
    TGT_IOR = 3'b010,
    TGT_IDR = 3'b011
  } tgt_e;

  typedef enum logic [1:0] {
    MODE_WRAP  = 2'd0,
    MODE_RANGE = 2'd1,
    MODE_HALT  = 2'd2,
    MODE_MOD   = 2'd3
  } cmode_e;

  typedef struct packed {
    logic [1:0] qmode;
    cmode_e     cmode;
  } cmr_t;

  typedef struct packed {
    logic [1:0] fsrc;
    logic       idx_ld_n;
    logic       ab_en;
  } ior_t;

  typedef struct packed {
    logic pol;
    logic sync;
  } idr_t;

  typedef struct packed {
    logic clr_cnt;
    logic clr_flags;
    logic clr_err;
    logic ld_cnt;
    logic latch;
    logic ld_psc;
  } cmd_t;
endpackage

// File: rtl/qcnt_hostregs.sv
module qcnt_hostregs import qcnt_pkg::*; #(
  parameter int CW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          addr_i,
  input  logic [7:0]    wdata_i,
  input  logic [CW-1:0] count_i,
  output logic [CW-1:0] preset_o,
  output logic [CW-1:0] latch_o,
  output logic [$clog2(CW/8)-1:0] bp_o,
  output cmr_t          cmr_o,
  output ior_t          ior_o,
  output idr_t          idr_o,
  output logic [7:0]    psc_o,
  output cmd_t          cmd_o
);
  localparam int NB  = CW / 8;
  localparam int BPW = $clog2(NB);

  logic           ctl_wr, dat_wr, dat_acc, rld;
  logic [1:0]     xfer, sub;
  logic [BPW-1:0] bp_q;
  logic [7:0]     lane_q [NB];

  assign ctl_wr  = wr_i & addr_i;
  assign dat_wr  = wr_i & ~addr_i;
  assign dat_acc = (wr_i | rd_i) & ~addr_i;
  assign rld     = ctl_wr && (wdata_i[7:5] == TGT_RLD);
  assign xfer    = wdata_i[4:3];
  assign sub     = wdata_i[2:1];

  always_comb begin
    cmd_o           = '0;
    cmd_o.ld_cnt    = rld && (xfer == 2'd1);
    cmd_o.latch     = rld && (xfer == 2'd2);
    cmd_o.ld_psc    = rld && (xfer == 2'd3);
    cmd_o.clr_cnt   = rld && (xfer == 2'd0) && (sub == 2'd1);
    cmd_o.clr_flags = rld && (xfer == 2'd0) && (sub == 2'd2);
    cmd_o.clr_err   = rld && (xfer == 2'd0) && (sub == 2'd3);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  bp_q <= '0;
    else if (rld && wdata_i[0])   bp_q <= '0;
    else if (dat_acc)             bp_q <= (bp_q == BPW'(NB-1)) ? '0 : bp_q + 1'b1;
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            lane_q[b] <= '0;
      else if (dat_wr && bp_q == BPW'(b))     lane_q[b] <= wdata_i;
    end
    assign preset_o[8*b +: 8] = lane_q[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o <= '0;
      psc_o   <= '0;
      cmr_o   <= '0;
      ior_o   <= '0;
      idr_o   <= '0;
    end else begin
      if (cmd_o.latch)  latch_o <= count_i;
      if (cmd_o.ld_psc) psc_o   <= preset_o[7:0];
      if (ctl_wr && wdata_i[7:5] == TGT_CMR)
        cmr_o <= '{qmode: wdata_i[4:3], cmode: cmode_e'(wdata_i[2:1])};
      if (ctl_wr && wdata_i[7:5] == TGT_IOR)
        ior_o <= '{fsrc: wdata_i[4:3], idx_ld_n: wdata_i[1], ab_en: wdata_i[0]};
      if (ctl_wr && wdata_i[7:5] == TGT_IDR)
        idr_o <= '{pol: wdata_i[1], sync: wdata_i[0]};
    end
  end

  assign bp_o = bp_q;
endmodule

// File: rtl/qcnt_core.sv
module qcnt_core import qcnt_pkg::*; #(
  parameter int CW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          up_i,
  input  logic          index_i,
  input  logic          noise_i,
  input  logic [CW-1:0] preset_i,
  input  cmr_t          cmr_i,
  input  ior_t          ior_i,
  input  idr_t          idr_i,
  input  cmd_t          cmd_i,
  output logic [CW-1:0] count_o,
  output logic [7:0]    stat_o,
  output logic          flag_o,
  output logic          idx_hit_o
);
  localparam logic [CW-1:0] MAXV = '1;

  logic [CW-1:0] cnt_q, nxt;
  logic idx_q, idx_edge, go, cy, bw, stop;
  logic halt_q, ud_q, brw_q, cry_q, cmp_q, sgn_q, idf_q, err_q;

  assign idx_edge  = idr_i.pol ? (index_i & ~idx_q) : (~index_i & idx_q);
  assign idx_hit_o = idx_edge & ~ior_i.idx_ld_n & (~idr_i.sync | step_i);
  // counter commands and index loads outrank a count pulse
  assign go = step_i & ior_i.ab_en & ~(halt_q & (cmr_i.cmode == MODE_HALT))
            & ~cmd_i.clr_cnt & ~cmd_i.ld_cnt & ~idx_hit_o;

  always_comb begin
    nxt  = cnt_q;
    cy   = 1'b0;
    bw   = 1'b0;
    stop = 1'b0;
    if (up_i) begin
      unique case (cmr_i.cmode)
        MODE_WRAP:  if (cnt_q == MAXV) begin nxt = '0; cy = 1'b1; end
                    else nxt = cnt_q + 1'b1;
        MODE_RANGE: if (cnt_q >= preset_i) cy = 1'b1;
                    else nxt = cnt_q + 1'b1;
        MODE_HALT:  if (cnt_q == MAXV) begin nxt = '0; cy = 1'b1; stop = 1'b1; end
                    else nxt = cnt_q + 1'b1;
        MODE_MOD:   if (cnt_q >= preset_i) begin nxt = '0; cy = 1'b1; end
                    else nxt = cnt_q + 1'b1;
        default: ;
      endcase
    end else begin
      unique case (cmr_i.cmode)
        MODE_WRAP:  if (cnt_q == '0) begin nxt = MAXV; bw = 1'b1; end
                    else nxt = cnt_q - 1'b1;
        MODE_RANGE: if (cnt_q == '0) bw = 1'b1;
                    else nxt = cnt_q - 1'b1;
        MODE_HALT:  if (cnt_q == '0) begin nxt = MAXV; bw = 1'b1; stop = 1'b1; end
                    else nxt = cnt_q - 1'b1;
        MODE_MOD:   if (cnt_q == '0) begin nxt = preset_i; bw = 1'b1; end
                    else nxt = cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      halt_q <= 1'b0;
      ud_q   <= 1'b0;
      idx_q  <= 1'b0;
    end else begin
      idx_q <= index_i;
      if (cmd_i.clr_cnt) begin
        cnt_q  <= '0;
        halt_q <= 1'b0;
      end else if (cmd_i.ld_cnt || idx_hit_o) begin
        cnt_q  <= preset_i;
        halt_q <= 1'b0;
      end else if (go) begin
        cnt_q  <= nxt;
        ud_q   <= up_i;
        if (stop) halt_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brw_q <= 1'b0; cry_q <= 1'b0; cmp_q <= 1'b0;
      sgn_q <= 1'b0; idf_q <= 1'b0; err_q <= 1'b0;
    end else begin
      if (cmd_i.clr_flags) begin
        brw_q <= 1'b0; cry_q <= 1'b0; cmp_q <= 1'b0;
        sgn_q <= 1'b0; idf_q <= 1'b0;
      end else begin
        if (idx_hit_o) idf_q <= 1'b1;
        if (go) begin
          if (bw) begin brw_q <= 1'b1; sgn_q <= 1'b1; end
          if (cy) begin cry_q <= 1'b1; sgn_q <= 1'b0; end
          if (nxt == preset_i) cmp_q <= 1'b1;
        end
      end
      if (cmd_i.clr_err) err_q <= 1'b0;
      else if (noise_i)  err_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (ior_i.fsrc)
      2'd0:    flag_o = cry_q;
      2'd1:    flag_o = cmp_q;
      2'd2:    flag_o = cry_q | brw_q;
      default: flag_o = idf_q;
    endcase
  end

  assign count_o = cnt_q;
  assign stat_o  = {2'b00, ud_q, err_q, sgn_q, cmp_q, cry_q, brw_q};
endmodule

// File: rtl/qcnt_channel.sv
module qcnt_channel import qcnt_pkg::*; #(
  parameter int CW = 24
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       cnt_en_i,
  input  logic       cnt_up_i,
  input  logic       index_i,
  input  logic       noise_i,
  output logic       flag_o,
  output logic [7:0] psc_o,
  output logic [1:0] qmode_o
);
  localparam int NB  = CW / 8;
  localparam int BPW = $clog2(NB);

  logic [CW-1:0]  cnt_w, preset_w, latch_w;
  logic [BPW-1:0] bp_w;
  logic [7:0]     stat_w;
  logic [1:0]     mode_w;
  logic           ab_en_w, idx_hit_w;
  cmr_t cmr_w;
  ior_t ior_w;
  idr_t idr_w;
  cmd_t cmd_w;

  qcnt_hostregs #(.CW(CW)) u_regs (
    .clk_i, .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i,
    .count_i(cnt_w), .preset_o(preset_w), .latch_o(latch_w), .bp_o(bp_w),
    .cmr_o(cmr_w), .ior_o(ior_w), .idr_o(idr_w), .psc_o(psc_o), .cmd_o(cmd_w)
  );

  qcnt_core #(.CW(CW)) u_core (
    .clk_i, .rst_ni, .step_i(cnt_en_i), .up_i(cnt_up_i), .index_i, .noise_i,
    .preset_i(preset_w), .cmr_i(cmr_w), .ior_i(ior_w), .idr_i(idr_w), .cmd_i(cmd_w),
    .count_o(cnt_w), .stat_o(stat_w), .flag_o(flag_o), .idx_hit_o(idx_hit_w)
  );

  assign mode_w  = cmr_w.cmode;
  assign ab_en_w = ior_w.ab_en;
  assign qmode_o = cmr_w.qmode;
  assign rdata_o = addr_i ? stat_w : latch_w[8*bp_w +: 8];
endmodule

// File: rtl/qcnt_channel_chk.sv
module qcnt_channel_chk #(
  parameter int CW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic          addr_i,
  input logic [7:0]    wdata_i,
  input logic          cnt_en_i,
  input logic          cnt_up_i,
  input logic [CW-1:0] count,
  input logic [CW-1:0] preset,
  input logic [CW-1:0] latch,
  input logic [1:0]    mode,
  input logic          ab_en,
  input logic          idx_hit
);
  // R4
  clr_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i && wdata_i == 8'h02) |=> (count == '0));

  // R4
  latch_snap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i && wdata_i[7:5] == 3'b000 && wdata_i[4:3] == 2'b10) |=> (latch == $past(count)));

  // R5
  gated_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !idx_hit && !(cnt_en_i && ab_en)) |=> $stable(count));

  // R7
  range_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !idx_hit && cnt_en_i && ab_en && cnt_up_i && mode == 2'd1 && count == preset)
    |=> $stable(count));

  // R6
  wrap_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !idx_hit && cnt_en_i && ab_en && cnt_up_i && mode == 2'd0 && count == {CW{1'b1}})
    |=> (count == '0));

  // R11
  idx_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_hit && !(wr_i && addr_i)) |=> (count == $past(preset)));
endmodule

bind qcnt_channel qcnt_channel_chk #(.CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .cnt_en_i(cnt_en_i), .cnt_up_i(cnt_up_i), .count(cnt_w), .preset(preset_w),
  .latch(latch_w), .mode(mode_w), .ab_en(ab_en_w), .idx_hit(idx_hit_w)
);

// File: tb/sim_qcnt_channel.sv
`timescale 1ns/1ps
module sim_qcnt_channel;
  logic clk = 0, rst_n = 0;
  logic wr = 0, rd = 0, addr = 0, cnt_en = 0, up_s = 0, index = 0, noise = 0;
  logic [7:0] wdata = 0, rdata, psc;
  logic flag;
  logic [1:0] qmode;
  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  qcnt_channel u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cnt_en_i(cnt_en), .cnt_up_i(up_s), .index_i(index), .noise_i(noise),
    .flag_o(flag), .psc_o(psc), .qmode_o(qmode)
  );

  // monitor: compare each read against the scoreboard
  always @(negedge clk) begin
    #1;
    if (rd) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL unexpected read got=%02h exp=none", rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rdata !== e) begin
          bad++;
          $display("FAIL %s got=%02h exp=%02h", t, rdata, e);
        end
      end
    end
  end

  task automatic ctrl(input logic [7:0] b);
    @(negedge clk); addr = 1; wdata = b; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic dwr(input logic [7:0] b);
    @(negedge clk); addr = 0; wdata = b; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rdx(input logic a, input logic [7:0] e, input string t);
    @(negedge clk); addr = a; rd = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd = 0;
  endtask

  task automatic rd_latch(input logic [23:0] v, input string t);
    ctrl(8'h11);
    rdx(0, v[7:0], t); rdx(0, v[15:8], t); rdx(0, v[23:16], t);
  endtask

  task automatic set_preset(input logic [23:0] v);
    ctrl(8'h01);
    dwr(v[7:0]); dwr(v[15:8]); dwr(v[23:16]);
  endtask

  task automatic step(input logic u, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cnt_en = 1; up_s = u;
      @(negedge clk); cnt_en = 0;
    end
  endtask

  task automatic set_index(input logic v, input logic with_step);
    @(negedge clk); index = v; cnt_en = with_step; up_s = 1;
    @(negedge clk); cnt_en = 0;
  endtask

  task automatic chk(input logic [31:0] got, input logic [31:0] e, input string t);
    @(negedge clk); #1;
    total++;
    if (got !== e) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", t, got, e);
    end
  endtask

  initial begin
    #(4 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rdx(1, 8'h00, "R1 status");
    rdx(0, 8'h00, "R1 latch");
    chk(psc, 8'h00, "R1 psc");
    chk(qmode, 2'd0, "R1 qmode");
    chk(flag, 1'b0, "R1 flag");

    // R3 R4 load through preset, snapshot, byte order
    set_preset(24'h123456);
    ctrl(8'h08);
    rd_latch(24'h123456, "R4 preset to counter");
    rdx(0, 8'h56, "R3 pointer wrap");
    // R2 unused target code has no effect
    ctrl(8'hE5);
    rd_latch(24'h123456, "R2 ignored target");

    // R5 enabled counting up, direction flag
    ctrl(8'h43);
    step(1, 5);
    rd_latch(24'h12345B, "R5 count up");
    rdx(1, 8'h20, "R5 up flag");
    ctrl(8'h42);
    step(1, 4);
    rd_latch(24'h12345B, "R5 disabled ignored");
    ctrl(8'h43);
    step(0, 3);
    rd_latch(24'h123458, "R5 count down");
    rdx(1, 8'h00, "R5 down flag");

    // R6 wrap mode
    ctrl(8'h02);
    step(0, 1);
    rd_latch(24'hFFFFFF, "R6 wrap down");
    rdx(1, 8'h09, "R6 borrow sign");
    step(1, 1);
    rd_latch(24'h000000, "R6 wrap up");
    rdx(1, 8'h23, "R6 carry");
    ctrl(8'h04);
    rdx(1, 8'h20, "R10 flags cleared");

    // R7 range limit
    ctrl(8'h22);
    set_preset(24'h000005);
    ctrl(8'h02);
    step(1, 7);
    rd_latch(24'h000005, "R7 hold at preset");
    rdx(1, 8'h26, "R7 carry compare");
    ctrl(8'h04); ctrl(8'h02);
    step(0, 2);
    rd_latch(24'h000000, "R7 hold at zero");
    rdx(1, 8'h09, "R7 borrow");

    // R8 non-recycle
    ctrl(8'h24); ctrl(8'h04);
    set_preset(24'hFFFFFE);
    ctrl(8'h08);
    step(1, 3);
    rd_latch(24'h000000, "R8 stop after carry");
    rdx(1, 8'h22, "R8 carry");
    ctrl(8'h08);
    step(1, 1);
    rd_latch(24'hFFFFFF, "R8 released by load");

    // R9 modulo-N
    ctrl(8'h26);
    set_preset(24'h000003);
    ctrl(8'h02); ctrl(8'h04);
    step(1, 5);
    rd_latch(24'h000001, "R9 up reload zero");
    step(0, 3);
    rd_latch(24'h000002, "R9 down reload preset");

    // R11 index loads
    ctrl(8'h41); ctrl(8'h62); ctrl(8'h02);
    set_index(1, 0);
    rd_latch(24'h000003, "R11 rising load");
    set_index(0, 0);
    ctrl(8'h02); ctrl(8'h60);
    set_index(1, 0);
    rd_latch(24'h000000, "R11 negative ignores rise");
    set_index(0, 0);
    rd_latch(24'h000003, "R11 falling load");
    ctrl(8'h63); ctrl(8'h02);
    set_index(1, 0);
    rd_latch(24'h000000, "R11 sync needs pulse");
    set_index(0, 0);
    set_index(1, 1);
    rd_latch(24'h000003, "R11 sync load");
    set_index(0, 0);

    // R10 error flag
    ctrl(8'h43); ctrl(8'h04);
    rdx(1, 8'h00, "R10 status clean");
    @(negedge clk); noise = 1;
    @(negedge clk); noise = 0;
    rdx(1, 8'h10, "R10 error set");
    ctrl(8'h06);
    rdx(1, 8'h00, "R10 error cleared");

    // R12 prescaler and resolution
    set_preset(24'h00007A);
    ctrl(8'h19);
    chk(psc, 8'h7A, "R12 psc");
    rdx(0, 8'h03, "R3 pointer reset by combined code");
    ctrl(8'h38);
    chk(qmode, 2'd3, "R12 qmode");

    // R13 flag source
    ctrl(8'h4B);
    ctrl(8'h08);
    step(0, 1);
    chk(flag, 1'b0, "R13 compare not yet");
    step(1, 1);
    chk(flag, 1'b1, "R13 compare source");
    ctrl(8'h43);
    chk(flag, 1'b0, "R13 carry source");

    // R14 clear wins over a count pulse
    ctrl(8'h08);
    @(negedge clk); addr = 1; wdata = 8'h02; wr = 1; cnt_en = 1; up_s = 1;
    @(negedge clk); wr = 0; cnt_en = 0;
    rd_latch(24'h000000, "R14 clear over pulse");

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule